// File: doc/BRIEF.md
# Byte-Lane Pixel Assembler for TFT Panels

This block sits between a parallel video port and an 18-bit TFT panel. The video port delivers, on every port clock, either a whole 16-bit RGB565 word or one byte of a pixel. In the byte modes the block gathers two bytes (RGB565) or three bytes (RGB888) per pixel, most significant byte first. It rebuilds the pixel, converts it to the panel's 6-6-6 layout and presents it with a one-port-clock pixel strobe. The horizontal and vertical syncs are active low. They travel through the same pipeline, so they stay aligned with the pixels.

Each mode has a fixed pipeline latency, measured in port clocks. The upstream timing generator can therefore move its first-valid-pixel point by exactly that amount. A falling edge on the horizontal sync restarts the byte count, so a pixel never combines bytes from two lines. Data enable is raised only while a pixel is being presented and both syncs are inactive.

Top module: `byte_pixel_packer`

## Requirements
- R1: Lane mode 0 (and the reserved code 3) takes a full RGB565 word from `port_data[15:0]` on every port clock. A word sampled on edge k appears on `pix_rgb` after edge k, with `pix_clk` high on every cycle after the first edge out of reset.
- R2: Lane mode 1 takes RGB565 as two bytes on `port_data[7:0]`, upper byte first, and ignores `port_data[15:8]`. A pixel whose first byte is sampled on edge k appears after edge k+3, with `pix_clk` high for that one cycle.
- R3: Lane mode 2 takes RGB888 as three bytes on `port_data[7:0]`, upper byte first, and ignores `port_data[15:8]`. A pixel whose first byte is sampled on edge k appears after edge k+5, with `pix_clk` high for that one cycle.
- R4: A 565 word holds its upper color in bits 15:11, green in bits 10:5 and its lower color in bits 4:0. On `pix_rgb` the red field sits in bits 17:12, green in 11:6 and blue in 5:0. Each 5-bit color is widened to 6 bits by appending its own most significant bit.
- R5: A 24-bit pixel holds its upper color in bits 23:16, green in 15:8 and its lower color in 7:0. Each color is cut to 6 bits by dropping its two lowest bits.
- R6: With `bgr_sel` low, the upper color is red and the lower color is blue. With `bgr_sel` high, the upper color is blue and the lower color is red, in both 565 and 888 words.
- R7: A port clock on which `hs_n_in` is low after being high the clock before carries byte 0 of a new pixel. Bytes already gathered for an unfinished pixel are dropped.
- R8: `hs_n_out` and `vs_n_out` after edge e equal `hs_n_in` and `vs_n_in` sampled on edge e-L, where L is 0, 3 or 5 for lane modes 0, 1 and 2.
- R9: `de_out` is high exactly when `pix_clk`, `hs_n_out` and `vs_n_out` are all high.
- R10: While `rst_n` is low, `pix_rgb` is 0, `pix_clk` and `de_out` are 0, and both sync outputs are high.
- R11: In the byte modes `pix_rgb` holds its value on every cycle where `pix_clk` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_mode | input | 2 | 0: 16-bit 565, 1: 565 in bytes, 2: 888 in bytes, 3: as 0 |
| bgr_sel | input | 1 | Swap the upper and lower color fields |
| port_data | input | 16 | Video port data; only bits 7:0 are used in byte modes |
| hs_n_in | input | 1 | Horizontal sync from the port, active low |
| vs_n_in | input | 1 | Vertical sync from the port, active low |
| pix_rgb | output | 18 | Panel pixel, red 17:12, green 11:6, blue 5:0 |
| pix_clk | output | 1 | Pixel strobe, high for one port clock per pixel |
| hs_n_out | output | 1 | Delayed horizontal sync, active low |
| vs_n_out | output | 1 | Delayed vertical sync, active low |
| de_out | output | 1 | Data enable for the panel |

## Verification
A falling edge of the horizontal sync can land on the same port clock that would otherwise carry the middle or last byte of a pixel. In that cycle the byte restart and the pixel commit compete. The bench drives line lengths that are not multiples of two or three, and adds extra sync pulses at odd offsets, so that this collision occurs in both byte modes. A behavioural model restarts its own byte count on the sync edge. The pixel value, the strobe, both delayed syncs and data enable are compared with that model on every clock, so a pixel wrongly committed from mixed bytes shows up as a pixel or strobe miscompare.

// File: rtl/bpp_pkg.sv
package bpp_pkg;

  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int WIDE_W  = 3 * BYTE_W;
  localparam int CLR_W   = 6;
  localparam int PIX_W   = 3 * CLR_W;
  localparam int LAT_MAX = 5;
  localparam int TAP_MAX = 3;

  typedef enum logic [1:0] {
    MODE_W16 = 2'd0,
    MODE_565 = 2'd1,
    MODE_888 = 2'd2,
    MODE_RSV = 2'd3
  } lane_mode_e;

  typedef struct packed {
    logic             ok;
    logic [PIX_W-1:0] rgb;
  } pix_slot_t;

  // bytes per pixel
  function automatic logic [1:0] beats_of(lane_mode_e m);
    case (m)
      MODE_565: beats_of = 2'd2;
      MODE_888: beats_of = 2'd3;
      default:  beats_of = 2'd1;
    endcase
  endfunction

  // port clocks from first byte to presentation
  function automatic logic [2:0] lat_of(lane_mode_e m);
    case (m)
      MODE_565: lat_of = 3'd3;
      MODE_888: lat_of = 3'd5;
      default:  lat_of = 3'd0;
    endcase
  endfunction

  // extra pixel stages after the commit register
  function automatic logic [1:0] tap_of(lane_mode_e m);
    logic [2:0] t;
    t = lat_of(m) - {1'b0, beats_of(m)} + 3'd1;
    tap_of = t[1:0];
  endfunction

endpackage

// File: rtl/bpp_byte_gather.sv
module bpp_byte_gather
  import bpp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  lane_mode_e        mode,
  input  logic [WORD_W-1:0] port_data,
  input  logic              hs_n,
  output logic [WIDE_W-1:0] word,
  output logic              commit
);

  logic [1:0]        cnt_q, cnt_d;
  logic [1:0]        idx;
  logic [1:0]        nbeat;
  logic              hs_prev_q;
  logic              line_start;
  logic [WORD_W-1:0] acc_q, acc_d;
  logic [BYTE_W-1:0] cur_byte;

  assign cur_byte   = port_data[BYTE_W-1:0];
  assign nbeat      = beats_of(mode);
  assign line_start = hs_prev_q & ~hs_n;

  always_comb begin
    idx    = line_start ? 2'd0 : cnt_q;
    commit = (idx == nbeat - 2'd1);
    cnt_d  = commit ? 2'd0 : idx + 2'd1;
    acc_d  = {acc_q[BYTE_W-1:0], cur_byte};
    case (mode)
      MODE_565: word = {{BYTE_W{1'b0}}, acc_q[BYTE_W-1:0], cur_byte};
      MODE_888: word = {acc_q, cur_byte};
      default:  word = {{BYTE_W{1'b0}}, port_data};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= 2'd0;
      hs_prev_q <= 1'b1;
      acc_q     <= '0;
    end else begin
      cnt_q     <= cnt_d;
      hs_prev_q <= hs_n;
      acc_q     <= acc_d;
    end
  end

endmodule

// File: rtl/bpp_color_map.sv
module bpp_color_map
  import bpp_pkg::*;
(
  input  lane_mode_e        mode,
  input  logic              bgr,
  input  logic [WIDE_W-1:0] word,
  output logic [PIX_W-1:0]  pix
);

  logic [CLR_W-1:0] up_c, mid_c, lo_c;
  logic             unused_bits;

  assign unused_bits = ^word[17:16];

  always_comb begin
    if (mode == MODE_888) begin
      up_c  = word[23:18];
      mid_c = word[15:10];
      lo_c  = word[7:2];
    end else begin
      up_c  = {word[15:11], word[15]};
      mid_c = word[10:5];
      lo_c  = {word[4:0], word[4]};
    end
    if (bgr) pix = {lo_c, mid_c, up_c};
    else     pix = {up_c, mid_c, lo_c};
  end

endmodule

// File: rtl/bpp_align_pipe.sv
module bpp_align_pipe
  import bpp_pkg::*;
#(
  parameter int PSTG = TAP_MAX + 1,
  parameter int SSTG = LAT_MAX + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lane_mode_e       mode,
  input  logic             commit,
  input  logic [PIX_W-1:0] pix_d,
  input  logic             hs_n,
  input  logic             vs_n,
  output logic [PIX_W-1:0] pix_q,
  output logic             stb_q,
  output logic             hs_q,
  output logic             vs_q
);

  pix_slot_t  slot_q [PSTG];
  pix_slot_t  slot_d [PSTG];
  logic [1:0] sync_q [SSTG];
  logic [1:0] sync_d [SSTG];
  logic [1:0] tap;
  logic [2:0] lat;

  always_comb begin
    slot_d[0].ok  = commit;
    slot_d[0].rgb = commit ? pix_d : slot_q[0].rgb;
    sync_d[0]     = {hs_n, vs_n};
    for (int i = 1; i < PSTG; i++) slot_d[i] = slot_q[i-1];
    for (int i = 1; i < SSTG; i++) sync_d[i] = sync_q[i-1];
  end

  for (genvar g = 0; g < PSTG; g++) begin : g_pix
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= '0;
      else        slot_q[g] <= slot_d[g];
    end
  end

  for (genvar g = 0; g < SSTG; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= 2'b11;
      else        sync_q[g] <= sync_d[g];
    end
  end

  assign tap   = tap_of(mode);
  assign lat   = lat_of(mode);
  assign pix_q = slot_q[tap].rgb;
  assign stb_q = slot_q[tap].ok;
  assign hs_q  = sync_q[lat][1];
  assign vs_q  = sync_q[lat][0];

endmodule

// File: rtl/byte_pixel_packer.sv
module byte_pixel_packer
  import bpp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        lane_mode,
  input  logic              bgr_sel,
  input  logic [WORD_W-1:0] port_data,
  input  logic              hs_n_in,
  input  logic              vs_n_in,
  output logic [PIX_W-1:0]  pix_rgb,
  output logic              pix_clk,
  output logic              hs_n_out,
  output logic              vs_n_out,
  output logic              de_out
);

  lane_mode_e        mode;
  logic [WIDE_W-1:0] word;
  logic              commit;
  logic [PIX_W-1:0]  pix_new;

  assign mode = lane_mode_e'(lane_mode);

  bpp_byte_gather u_gather (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .port_data (port_data),
    .hs_n      (hs_n_in),
    .word      (word),
    .commit    (commit)
  );

  bpp_color_map u_map (
    .mode (mode),
    .bgr  (bgr_sel),
    .word (word),
    .pix  (pix_new)
  );

  bpp_align_pipe u_pipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .commit (commit),
    .pix_d  (pix_new),
    .hs_n   (hs_n_in),
    .vs_n   (vs_n_in),
    .pix_q  (pix_rgb),
    .stb_q  (pix_clk),
    .hs_q   (hs_n_out),
    .vs_q   (vs_n_out)
  );

  assign de_out = pix_clk & hs_n_out & vs_n_out;

endmodule

// File: rtl/bpp_checker.sv
module bpp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  lane_mode,
  input logic [17:0] pix_rgb,
  input logic        pix_clk,
  input logic        hs_n_in,
  input logic        vs_n_in,
  input logic        hs_n_out,
  input logic        vs_n_out,
  input logic        de_out
);

  logic [2:0] since_q;
  logic       byte_mode;

  assign byte_mode = (lane_mode == 2'd1) || (lane_mode == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_q <= 3'd0;
    else if (since_q != 3'd7) since_q <= since_q + 3'd1;
  end

  // R1
  full_word_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_mode == 2'd0 || lane_mode == 2'd3) && since_q >= 3'd1) |-> pix_clk);

  // R2
  half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode == 2'd1 && pix_clk) |=> !pix_clk);

  // R3
  third_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode == 2'd2 && pix_clk) |=> !pix_clk);

  // R8
  sync_w16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_mode == 2'd0 || lane_mode == 2'd3) && since_q >= 3'd1) |->
      (hs_n_out == $past(hs_n_in) && vs_n_out == $past(vs_n_in)));

  // R8
  sync_565_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode == 2'd1 && since_q >= 3'd4) |->
      (hs_n_out == $past(hs_n_in, 4) && vs_n_out == $past(vs_n_in, 4)));

  // R8
  sync_888_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode == 2'd2 && since_q >= 3'd6) |->
      (hs_n_out == $past(hs_n_in, 6) && vs_n_out == $past(vs_n_in, 6)));

  // R9
  de_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_out |-> (pix_clk && hs_n_out && vs_n_out));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_mode && since_q >= 3'd1 && !pix_clk) |-> $stable(pix_rgb));

endmodule

bind byte_pixel_packer bpp_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lane_mode (lane_mode),
  .pix_rgb   (pix_rgb),
  .pix_clk   (pix_clk),
  .hs_n_in   (hs_n_in),
  .vs_n_in   (vs_n_in),
  .hs_n_out  (hs_n_out),
  .vs_n_out  (vs_n_out),
  .de_out    (de_out)
);

// File: tb/byte_pixel_packer_test.sv
module byte_pixel_packer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  lane_mode;
  logic        bgr_sel;
  logic [15:0] port_data;
  logic        hs_n_in, vs_n_in;
  logic [17:0] pix_rgb;
  logic        pix_clk, hs_n_out, vs_n_out, de_out;

  always #4 clk = ~clk;

  byte_pixel_packer uut (
    .clk(clk), .rst_n(rst_n), .lane_mode(lane_mode), .bgr_sel(bgr_sel),
    .port_data(port_data), .hs_n_in(hs_n_in), .vs_n_in(vs_n_in),
    .pix_rgb(pix_rgb), .pix_clk(pix_clk), .hs_n_out(hs_n_out),
    .vs_n_out(vs_n_out), .de_out(de_out)
  );

  int n_vec = 0;
  int n_bad = 0;

  int cur_pix [0:1023];
  bit cflag   [0:1023];
  bit hs_h    [0:1023];
  bit vs_h    [0:1023];

  function automatic int nbeats(int m);
    return (m == 1) ? 2 : (m == 2) ? 3 : 1;
  endfunction

  function automatic int latency(int m);
    return (m == 1) ? 3 : (m == 2) ? 5 : 0;
  endfunction

  function automatic int to_panel(int m, bit bgr, int w);
    int up, mid, lo, r, b;
    if (m == 2) begin
      up = (w >> 18) & 63; mid = (w >> 10) & 63; lo = (w >> 2) & 63;
    end else begin
      up  = (w >> 11) & 31; up = (up << 1) | (up >> 4);
      mid = (w >> 5) & 63;
      lo  = w & 31;         lo = (lo << 1) | (lo >> 4);
    end
    r = bgr ? lo : up;
    b = bgr ? up : lo;
    return (r << 12) | (mid << 6) | b;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_seg(int m, bit bgr, int ncyc, int line_len, bit jitter);
    int cnt, acc, latest, e, nb, lat, jj, idx, w, bt;
    bit hsp, fall, com, ehs, evs, eclk;
    int epix;
    string ptag;
    ptag = (m == 1) ? "R2 R4" : (m == 2) ? "R3 R5" : "R1 R4";
    if (bgr)    ptag = {ptag, " R6"};
    if (jitter) ptag = {ptag, " R7"};
    // reset phase, R10
    rst_n = 1'b0; lane_mode = m[1:0]; bgr_sel = bgr;
    port_data = 16'hA5C3; hs_n_in = 1'b1; vs_n_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 pix_rgb", int'(pix_rgb), 0);
    check("R10 pix_clk", int'(pix_clk), 0);
    check("R10 hs_n_out", int'(hs_n_out), 1);
    check("R10 vs_n_out", int'(vs_n_out), 1);
    check("R10 de_out", int'(de_out), 0);
    rst_n = 1'b1;
    cnt = 0; acc = 0; latest = 0; e = 0; hsp = 1'b1;
    nb = nbeats(m); lat = latency(m); jj = lat - (nb - 1);
    for (int c = 0; c < ncyc; c++) begin
      port_data = 16'($urandom);
      hs_n_in   = !((c % line_len) < 2 || (jitter && (c % 29) == 17));
      vs_n_in   = !((c % 150) < 5);
      @(posedge clk);
      @(negedge clk);
      // behavioural model of edge e
      bt   = int'(port_data[7:0]);
      fall = hsp && !hs_n_in;
      idx  = fall ? 0 : cnt;
      com  = (idx == nb - 1);
      if (m == 1)      w = ((acc & 255) << 8) | bt;
      else if (m == 2) w = ((acc & 65535) << 8) | bt;
      else             w = int'(port_data);
      if (com) latest = to_panel(m, bgr, w);
      cnt = com ? 0 : idx + 1;
      acc = ((acc << 8) | bt) & 65535;
      hsp = hs_n_in;
      cur_pix[e] = latest; cflag[e] = com;
      hs_h[e] = hs_n_in;   vs_h[e] = vs_n_in;
      if (e - jj < 0) begin epix = 0; eclk = 1'b0; end
      else begin epix = cur_pix[e - jj]; eclk = cflag[e - jj]; end
      if (e - lat < 0) begin ehs = 1'b1; evs = 1'b1; end
      else begin ehs = hs_h[e - lat]; evs = vs_h[e - lat]; end
      check(eclk ? ptag : {ptag, " R11"}, int'(pix_rgb), epix);
      check(ptag, int'(pix_clk), int'(eclk));
      check("R8 hs_n_out", int'(hs_n_out), int'(ehs));
      check("R8 vs_n_out", int'(vs_n_out), int'(evs));
      check("R9 de_out", int'(de_out), int'(eclk && ehs && evs));
      e++;
    end
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lane_mode = 2'd0; bgr_sel = 1'b0;
    port_data = '0; hs_n_in = 1'b1; vs_n_in = 1'b1;
    run_seg(0, 1'b0, 400, 40, 1'b0);  // R1 R4
    run_seg(0, 1'b1, 400, 40, 1'b0);  // R1 R6
    run_seg(3, 1'b0, 300, 40, 1'b0);  // R1 reserved code
    run_seg(1, 1'b0, 400, 37, 1'b0);  // R2 R4 odd line length
    run_seg(1, 1'b1, 400, 37, 1'b1);  // R2 R6 R7
    run_seg(2, 1'b0, 400, 41, 1'b0);  // R3 R5
    run_seg(2, 1'b1, 400, 38, 1'b1);  // R3 R6 R7
    run_seg(2, 1'b0, 400, 40, 1'b1);  // R7 R8 R9
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule